// File: doc/BRIEF.md
# Register-Write Command Stream Packer

This block turns a stream of register-write requests into a command buffer in memory. Each request carries a 20-bit register offset, a 32-bit value and a flag that marks the target as an auto-increment register. The block does not store the buffer itself. It drives a dword-wide write port, and an external block RAM holds the buffer. Every instruction starts on an even dword, so all instructions are 8-byte aligned.

A plain request becomes a two-dword direct-write instruction. An indexed request opens an indexed-write instruction: a size dword, a header dword, and then the data words. A following indexed request to the same offset does not open a new instruction. Its value is appended, and the block goes back and rewrites the size dword. When an indexed instruction holds an odd number of dwords, the dword after its last value is written as zero.

A commit pulse zero-fills the buffer up to the next 64-byte line and reports the final byte tail with a one-cycle done pulse. A clear pulse discards the buffer contents and restarts at dword zero.

Top module: `cmdpk_packer`

## Requirements
- R1: A non-indexed request writes two dwords starting at the first even index at or above the write pointer. The first dword is the value. The second dword is the header: 0x01 in bits 31:24, 0xF in bits 23:20, and the offset in bits 19:0.
- R2: An indexed request that opens an instruction writes three dwords from the even start index. They are the size dword (1), the header (0x09 in bits 31:24, zero in bits 23:20, the offset in bits 19:0), and the value.
- R3: Every instruction starts at an even dword index. An odd write pointer is rounded up by one before the instruction is placed.
- R4: An indexed request whose offset matches the open indexed instruction writes its value at the write pointer. It then rewrites that instruction's size dword with the new count of data words.
- R5: When an indexed instruction ends with an odd number of dwords in total (size, header and values), the dword after its last value is written as zero.
- R6: A non-indexed request closes any open indexed instruction. A later indexed request to the same offset therefore opens a new instruction.
- R7: The buffer holds 2048 dwords (8192 bytes). A request whose instruction would end past dword 2047 is not stored and writes nothing. Such a request raises the overflow flag, which stays high until clear.
- R8: After a commit, the reported tail equals the write pointer in bytes rounded up to a multiple of 64. Every dword from the write pointer up to the tail is written as zero. The done output then pulses for exactly one cycle.
- R9: Request ready is low from commit until done. A commit that arrives while a request is still being written takes effect after that request completes.
- R10: After done, or after clear, the next instruction starts at dword 0 and never merges with an instruction written before.
- R11: After reset, ready is high, overflow and done are low, the tail is 0 and no buffer write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_indexed | input | 1 | Target is an auto-increment register |
| req_offset | input | 20 | Register offset |
| req_data | input | 32 | Value to write |
| commit | input | 1 | Pad the buffer and report the tail |
| clear | input | 1 | Discard the buffer and clear overflow |
| buf_we | output | 1 | Buffer write strobe |
| buf_addr | output | 11 | Buffer dword index |
| buf_wdata | output | 32 | Buffer dword value |
| overflow | output | 1 | Sticky: a request was dropped for lack of room |
| tail | output | 14 | Byte tail of the last commit |
| done | output | 1 | One-cycle pulse when the tail is valid |

## Verification
The assertions check, on every cycle, the properties that hold regardless of what has been written: the write pointer never passes capacity, a new instruction begins on an even dword, overflow stays set, padding writes carry zero, done is a single-cycle pulse with a line-aligned tail, and the pointer returns to zero after done. Only the bench's scenarios can show that the final buffer image is correct. That means the merged size words, the zero dwords after odd payloads, the closing effect of a direct write, and the exact fit limit at the end of the buffer, each compared against dword values worked out from the requirements.

// File: rtl/cmdpk_pkg.sv
package cmdpk_pkg;
  localparam int REG_OFF_W = 20;
  localparam logic [7:0] OPC_DIRECT  = 8'h01;
  localparam logic [7:0] OPC_INDEXED = 8'h09;
  localparam logic [3:0] BYTE_EN_ALL = 4'hF;

  typedef enum logic [2:0] {
    S_IDLE, S_DHDR, S_XHDR, S_XVAL, S_XSIZE, S_XPAD, S_FILL
  } pk_state_t;

  function automatic logic [31:0] direct_hdr(input logic [REG_OFF_W-1:0] off);
    return {OPC_DIRECT, BYTE_EN_ALL, off};
  endfunction

  function automatic logic [31:0] indexed_hdr(input logic [REG_OFF_W-1:0] off);
    return {OPC_INDEXED, 4'h0, off};
  endfunction
endpackage

// File: rtl/cmdpk_fit.sv
module cmdpk_fit #(
  parameter int CAP_DW = 2048,
  parameter int PTR_W  = 12
) (
  input  logic [PTR_W-1:0]               wptr,
  input  logic                           open_vld,
  input  logic [cmdpk_pkg::REG_OFF_W-1:0] open_off,
  input  logic                           req_indexed,
  input  logic [cmdpk_pkg::REG_OFF_W-1:0] req_offset,
  output logic [PTR_W-1:0]               base,
  output logic                           merge,
  output logic                           reject
);
  localparam int SUM_W = PTR_W + 1;

  logic [SUM_W-1:0] first_dw;
  logic [SUM_W-1:0] need_dw;

  always_comb begin
    base     = wptr + {{(PTR_W-1){1'b0}}, wptr[0]};
    merge    = req_indexed && open_vld && (req_offset == open_off);
    first_dw = merge ? {1'b0, wptr} : {1'b0, base};
    if (merge)            need_dw = SUM_W'(1);
    else if (req_indexed) need_dw = SUM_W'(3);
    else                  need_dw = SUM_W'(2);
    reject   = (first_dw + need_dw) > SUM_W'(CAP_DW);
  end
endmodule

// File: rtl/cmdpk_line_end.sv
module cmdpk_line_end #(
  parameter int PTR_W   = 12,
  parameter int LINE_SH = 4
) (
  input  logic [PTR_W-1:0] wptr,
  output logic [PTR_W-1:0] line_end
);
  localparam logic [PTR_W-1:0] LINE_MASK = PTR_W'((1 << LINE_SH) - 1);

  logic [PTR_W-1:0] bumped;

  always_comb begin
    bumped   = wptr + LINE_MASK;
    line_end = bumped & ~LINE_MASK;
  end
endmodule

// File: rtl/cmdpk_packer.sv
module cmdpk_packer #(
  parameter int BUF_BYTES  = 8192,
  parameter int LINE_BYTES = 64,
  localparam int CAP_DW    = BUF_BYTES / 4,
  localparam int ADDR_W    = $clog2(CAP_DW),
  localparam int PTR_W     = ADDR_W + 1,
  localparam int TAIL_W    = PTR_W + 2,
  localparam int LINE_SH   = $clog2(LINE_BYTES / 4)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic                            req_indexed,
  input  logic [cmdpk_pkg::REG_OFF_W-1:0] req_offset,
  input  logic [31:0]                     req_data,
  input  logic                            commit,
  input  logic                            clear,
  output logic                            buf_we,
  output logic [ADDR_W-1:0]               buf_addr,
  output logic [31:0]                     buf_wdata,
  output logic                            overflow,
  output logic [TAIL_W-1:0]               tail,
  output logic                            done
);
  import cmdpk_pkg::*;

  pk_state_t               state;
  logic [PTR_W-1:0]        wptr;
  logic [PTR_W-1:0]        open_start;
  logic                    open_vld;
  logic [REG_OFF_W-1:0]    open_off;
  logic [31:0]             open_cnt;
  logic [REG_OFF_W-1:0]    hold_off;
  logic [31:0]             hold_data;
  logic [PTR_W-1:0]        fill_end;
  logic                    commit_pend;

  logic [PTR_W-1:0]        base;
  logic                    merge;
  logic                    reject;
  logic [PTR_W-1:0]        line_end;
  logic                    accept;

  cmdpk_fit #(.CAP_DW(CAP_DW), .PTR_W(PTR_W)) u_fit (
    .wptr        (wptr),
    .open_vld    (open_vld),
    .open_off    (open_off),
    .req_indexed (req_indexed),
    .req_offset  (req_offset),
    .base        (base),
    .merge       (merge),
    .reject      (reject)
  );

  cmdpk_line_end #(.PTR_W(PTR_W), .LINE_SH(LINE_SH)) u_line (
    .wptr     (wptr),
    .line_end (line_end)
  );

  assign req_ready = (state == S_IDLE) && !commit_pend;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      wptr        <= '0;
      open_start  <= '0;
      open_vld    <= 1'b0;
      open_off    <= '0;
      open_cnt    <= '0;
      hold_off    <= '0;
      hold_data   <= '0;
      fill_end    <= '0;
      commit_pend <= 1'b0;
      overflow    <= 1'b0;
      tail        <= '0;
      done        <= 1'b0;
      buf_we      <= 1'b0;
      buf_addr    <= '0;
      buf_wdata   <= '0;
    end else if (clear) begin
      state       <= S_IDLE;
      wptr        <= '0;
      open_start  <= '0;
      open_vld    <= 1'b0;
      open_cnt    <= '0;
      commit_pend <= 1'b0;
      overflow    <= 1'b0;
      done        <= 1'b0;
      buf_we      <= 1'b0;
    end else begin
      buf_we <= 1'b0;
      done   <= 1'b0;
      if (commit && state != S_IDLE && state != S_FILL) commit_pend <= 1'b1;
      case (state)
        S_IDLE: begin
          if (accept) begin
            if (commit) commit_pend <= 1'b1;
            if (reject) begin
              overflow <= 1'b1;
            end else if (merge) begin
              buf_we    <= 1'b1;
              buf_addr  <= wptr[ADDR_W-1:0];
              buf_wdata <= req_data;
              wptr      <= wptr + 1'b1;
              open_cnt  <= open_cnt + 1'b1;
              state     <= S_XSIZE;
            end else if (req_indexed) begin
              buf_we     <= 1'b1;
              buf_addr   <= base[ADDR_W-1:0];
              buf_wdata  <= 32'd1;
              open_vld   <= 1'b1;
              open_start <= base;
              open_off   <= req_offset;
              open_cnt   <= 32'd1;
              hold_data  <= req_data;
              wptr       <= base + PTR_W'(2);
              state      <= S_XHDR;
            end else begin
              buf_we    <= 1'b1;
              buf_addr  <= base[ADDR_W-1:0];
              buf_wdata <= req_data;
              open_vld  <= 1'b0;
              hold_off  <= req_offset;
              wptr      <= base + PTR_W'(2);
              state     <= S_DHDR;
            end
          end else if (commit || commit_pend) begin
            commit_pend <= 1'b0;
            fill_end    <= line_end;
            state       <= S_FILL;
          end
        end
        S_DHDR: begin
          buf_we    <= 1'b1;
          buf_addr  <= ADDR_W'(wptr - 1'b1);
          buf_wdata <= direct_hdr(hold_off);
          state     <= S_IDLE;
        end
        S_XHDR: begin
          buf_we    <= 1'b1;
          buf_addr  <= ADDR_W'(open_start + 1'b1);
          buf_wdata <= indexed_hdr(open_off);
          state     <= S_XVAL;
        end
        S_XVAL: begin
          buf_we    <= 1'b1;
          buf_addr  <= wptr[ADDR_W-1:0];
          buf_wdata <= hold_data;
          wptr      <= wptr + 1'b1;
          state     <= S_XPAD;
        end
        S_XSIZE: begin
          buf_we    <= 1'b1;
          buf_addr  <= open_start[ADDR_W-1:0];
          buf_wdata <= open_cnt;
          state     <= wptr[0] ? S_XPAD : S_IDLE;
        end
        S_XPAD: begin
          buf_we    <= 1'b1;
          buf_addr  <= wptr[ADDR_W-1:0];
          buf_wdata <= 32'd0;
          state     <= S_IDLE;
        end
        S_FILL: begin
          if (wptr != fill_end) begin
            buf_we    <= 1'b1;
            buf_addr  <= wptr[ADDR_W-1:0];
            buf_wdata <= 32'd0;
            wptr      <= wptr + 1'b1;
          end else begin
            done       <= 1'b1;
            tail       <= {fill_end, 2'b00};
            wptr       <= '0;
            open_start <= '0;
            open_vld   <= 1'b0;
            state      <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R7: the pointer never runs past the buffer
  p_ptr_in_cap_r7: assert property (@(posedge clk) disable iff (rst)
    wptr <= PTR_W'(CAP_DW));

  // R7: overflow stays set until clear
  p_no_overflow_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (overflow && !clear) |=> overflow);

  // R3: a freshly opened instruction lands on an even dword
  p_even_start_r3: assert property (@(posedge clk) disable iff (rst || clear)
    (accept && !merge && !reject) |=> (buf_we && !buf_addr[0]));

  // R8: padding writes are zero
  p_fill_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (buf_we && $past(state == S_FILL)) |-> (buf_wdata == 32'd0));

  // R8: done is a single pulse with a line-aligned tail
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_tail_aligned_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (tail[LINE_SH+1:0] == '0));

  // R9: no request is taken in the cycle before done
  p_ready_low_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(!req_ready));

  // R10: after done the pointer restarts at zero with nothing open
  p_restart_r10: assert property (@(posedge clk) disable iff (rst || clear)
    done |-> (wptr == '0 && !open_vld));
endmodule

// File: tb/cmdpk_packer_test.sv
`timescale 1ns/1ps
module cmdpk_packer_test;
  localparam int CAP = 2048;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_indexed = 1'b0;
  logic [19:0] req_offset = '0;
  logic [31:0] req_data = '0;
  logic        commit = 1'b0;
  logic        clear = 1'b0;
  logic        buf_we;
  logic [10:0] buf_addr;
  logic [31:0] buf_wdata;
  logic        overflow;
  logic [13:0] tail;
  logic        done;

  logic [31:0] mem [CAP];
  int          wcount = 0;
  int          n_chk = 0;
  int          n_fail = 0;
  int          cycles = 0;
  logic [13:0] last_tail;

  cmdpk_packer uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_indexed(req_indexed), .req_offset(req_offset), .req_data(req_data),
    .commit(commit), .clear(clear), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_wdata(buf_wdata), .overflow(overflow), .tail(tail), .done(done)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (buf_we) begin
      mem[buf_addr] = buf_wdata;
      wcount++;
    end
  end

  // stimulus {indexed, offset, data}
  localparam logic [52:0] VEC [7] = '{
    {1'b0, 20'h00100, 32'hA0000001},
    {1'b1, 20'h00200, 32'h000000B1},
    {1'b1, 20'h00200, 32'h000000B2},
    {1'b1, 20'h00200, 32'h000000B3},
    {1'b1, 20'h00300, 32'h000000C1},
    {1'b0, 20'h00300, 32'h000000D1},
    {1'b1, 20'h00300, 32'h000000E1}
  };

  localparam logic [31:0] EXP [18] = '{
    32'hA0000001, 32'h01F00100, 32'h00000003, 32'h09000200,
    32'h000000B1, 32'h000000B2, 32'h000000B3, 32'h00000000,
    32'h00000001, 32'h09000300, 32'h000000C1, 32'h00000000,
    32'h000000D1, 32'h01F00300, 32'h00000001, 32'h09000300,
    32'h000000E1, 32'h00000000
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wipe();
    for (int i = 0; i < CAP; i++) mem[i] = 32'hDEADBEEF;
  endtask

  task automatic send(input logic ind, input logic [19:0] off, input logic [31:0] dat);
    @(negedge clk);
    req_valid = 1'b1; req_indexed = ind; req_offset = off; req_data = dat;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_clear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_commit(input string tag);
    bit seen = 1'b0;
    @(negedge clk); commit = 1'b1;
    @(negedge clk); commit = 1'b0;
    for (int i = 0; i < 400 && !seen; i++) begin
      if (done) begin seen = 1'b1; last_tail = tail; end
      else @(negedge clk);
    end
    chk(seen, tag, 32'(seen), 32'd1);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    while (cycles < 150000) begin @(posedge clk); cycles++; end
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=<150000", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int wc;
    wipe();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(req_ready == 1'b1, "R11 ready", 32'(req_ready), 32'd1);
    chk(overflow == 1'b0, "R11 overflow", 32'(overflow), 32'd0);
    chk(done == 1'b0, "R11 done", 32'(done), 32'd0);
    chk(tail == '0, "R11 tail", 32'(tail), 32'd0);
    chk(wcount == 0, "R11 no write", 32'(wcount), 32'd0);

    // table walk: R1 R2 R3 R4 R5 R6, then commit R8 R9
    for (int v = 0; v < 7; v++) send(VEC[v][52], VEC[v][51:32], VEC[v][31:0]);
    do_commit("R8 done after table");
    for (int i = 0; i < 18; i++)
      chk(mem[i] == EXP[i], $sformatf("R1/R2/R4/R5/R6 dword %0d", i), mem[i], EXP[i]);
    for (int i = 18; i < 32; i++)
      chk(mem[i] == 32'd0, $sformatf("R8 fill dword %0d", i), mem[i], 32'd0);
    chk(mem[32] == 32'hDEADBEEF, "R8 no write past tail", mem[32], 32'hDEADBEEF);
    chk(last_tail == 14'd128, "R8 tail", 32'(last_tail), 32'd128);

    // R10 restart after commit
    send(1'b0, 20'h00005, 32'h00000077);
    settle();
    chk(mem[0] == 32'h77, "R10 value at 0", mem[0], 32'h77);
    chk(mem[1] == 32'h01F00005, "R1 header at 1", mem[1], 32'h01F00005);

    // R10 clear breaks merge
    send(1'b1, 20'h00040, 32'h11);
    settle();
    chk(mem[2] == 32'd1 && mem[4] == 32'h11, "R3 indexed at 2", mem[4], 32'h11);
    pulse_clear();
    send(1'b1, 20'h00040, 32'h22);
    settle();
    chk(mem[0] == 32'd1, "R10 size after clear", mem[0], 32'd1);
    chk(mem[1] == 32'h09000040, "R2 header after clear", mem[1], 32'h09000040);
    chk(mem[2] == 32'h22, "R10 value after clear", mem[2], 32'h22);
    chk(mem[3] == 32'd0, "R5 pad after clear", mem[3], 32'd0);

    // R8 empty commit
    pulse_clear();
    wc = wcount;
    do_commit("R8 empty done");
    chk(last_tail == 14'd0, "R8 empty tail", 32'(last_tail), 32'd0);
    chk(wcount == wc, "R8 empty no writes", 32'(wcount), 32'(wc));

    // R9 ready low during padding, commit pended behind a request
    pulse_clear();
    send(1'b0, 20'h00010, 32'h5);
    @(negedge clk); commit = 1'b1;
    @(negedge clk); commit = 1'b0;
    chk(req_ready == 1'b0, "R9 ready low", 32'(req_ready), 32'd0);
    begin
      bit seen = 1'b0;
      for (int i = 0; i < 100 && !seen; i++) begin
        if (done) begin seen = 1'b1; last_tail = tail; end
        else begin
          if (req_ready) chk(1'b0, "R9 ready during fill", 32'd1, 32'd0);
          @(negedge clk);
        end
      end
      chk(seen, "R9 done seen", 32'(seen), 32'd1);
    end
    chk(last_tail == 14'd64, "R8 tail one line", 32'(last_tail), 32'd64);
    chk(mem[1] == 32'h01F00010, "R9 request before padding", mem[1], 32'h01F00010);

    // R7 fit limit
    pulse_clear();
    for (int i = 0; i < 1023; i++) send(1'b0, 20'(i), 32'(i));
    settle();
    chk(overflow == 1'b0, "R7 no overflow at 2046", 32'(overflow), 32'd0);
    wc = wcount;
    send(1'b1, 20'h00007, 32'h99);
    settle();
    chk(overflow == 1'b1, "R7 indexed rejected", 32'(overflow), 32'd1);
    chk(wcount == wc, "R7 rejected writes nothing", 32'(wcount), 32'(wc));
    send(1'b0, 20'h00009, 32'hCAFE);
    settle();
    chk(mem[2046] == 32'hCAFE, "R7 last direct fits", mem[2046], 32'hCAFE);
    chk(mem[2047] == 32'h01F00009, "R7 last header", mem[2047], 32'h01F00009);
    wc = wcount;
    send(1'b0, 20'h0000A, 32'hBAD);
    settle();
    chk(wcount == wc, "R7 full writes nothing", 32'(wcount), 32'(wc));
    chk(overflow == 1'b1, "R7 sticky", 32'(overflow), 32'd1);
    do_commit("R8 full done");
    chk(last_tail == 14'd8192, "R8 full tail", 32'(last_tail), 32'd8192);
    pulse_clear();
    chk(overflow == 1'b0, "R7 cleared", 32'(overflow), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule